// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the raster timing for a progressive-scan display. Two counters run in the pixel clock domain: a pixel position within the line and a line position within the frame. A bank of registers, written through a simple write port, sets where each line and frame wraps, the size of the visible region and the hsync and vsync windows. Every position is programmed as an end-inclusive value, so each one is the real count minus one.

From the counters the block drives these registered outputs:

- a display-active flag;
- a pixel-enable flag that also honours a refresh bit and a display-off bit;
- hsync and vsync, each with its own polarity and power-saving suppression;
- a composite sync for embedding in the colour signal;
- a one-clock prefetch pulse at a programmable pixel position on every line, which a pixel fetch engine uses to start reading the next line early.

Software clears the enable bit, programs the geometry and then sets enable again. Writes are expected only while the generator is stopped. The first cycle after enabling always shows position (0,0). Line width is bounded by the counter width, which by default covers lines of up to 4096 active pixels with room for blanking.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, and on every cycle from the first edge at which the enable bit (control register at address 0, bit 0) reads 0, both counters are 0, and de, pix_en, prefetch and csync_rgb are 0. In that state hsync and vsync sit at their inactive level: the invert bit value, or 0 when suppressed.
- R2: While enabled, hcount starts at 0 on the first enabled cycle, increments by one per clock and returns to 0 on the cycle after it equals the line-total register (address 1).
- R3: vcount changes only when hcount wraps. It then increments, or returns to 0 if it equals the frame-total register (address 5). It starts at 0 on the first enabled cycle.
- R4: de is 1 exactly when hcount ≤ active-width register (address 2) and vcount ≤ active-height register (address 6), and the generator is enabled.
- R5: Before polarity is applied, hsync is active when hs_begin (address 3) < hcount ≤ hs_finish (address 4). vsync is active when vs_begin (address 7) < vcount ≤ vs_finish (address 8).
- R6: prefetch is 1 for exactly the cycles where hcount equals the prefetch-position register (address 9), on every line including vertical-blanking lines.
- R7: Sync control register (address 10) bit 3 inverts hsync and bit 4 inverts vsync.
- R8: Sync control bit 1 drives both hsync and vsync to 0 and forces csync_rgb to 0. Bit 5 drives only hsync to 0, and bit 6 drives only vsync to 0.
- R9: When sync control bit 0 is set and bit 1 is clear, csync_rgb equals the OR of the un-inverted hsync and vsync windows. Otherwise csync_rgb is 0.
- R10: pix_en equals de AND control bit 1 (refresh) AND NOT display-off (address 11, bit 1). Display-off and refresh do not alter hsync, vsync or the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register address |
| wr_data | input | HW (13) | Register write data |
| hcount | output | HW (13) | Pixel position within the line |
| vcount | output | VW (12) | Line position within the frame |
| de | output | 1 | Display-active region flag |
| pix_en | output | 1 | Colour output enable (de gated by refresh and display-off) |
| hsync | output | 1 | Horizontal sync after polarity and suppression |
| vsync | output | 1 | Vertical sync after polarity and suppression |
| csync_rgb | output | 1 | Composite sync for embedding in the colour signal |
| prefetch | output | 1 | One-clock line prefetch pulse |

## Verification
The embedded assertions check on every cycle that the counters step and wrap, that vcount holds within a line, that a stopped generator shows zeros, that the prefetch pulse lasts a single clock on lines longer than one pixel, that all-sync-off silences both syncs, and that pix_en never appears outside de. The exact placement of the sync windows and the visible region, the polarity and per-sync suppression combinations, and the composite sync can only be shown by the bench. It compares every output on every cycle of whole frames against a model of the register settings. The bench also covers degenerate geometries: a one-pixel line, a visible region that spans the whole frame, and empty sync windows.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HW = 13,
  parameter int VW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [HW-1:0] wr_data,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          de,
  output logic          pix_en,
  output logic          hsync,
  output logic          vsync,
  output logic          csync_rgb,
  output logic          prefetch
);

  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_HTOT  = AW'(1);
  localparam logic [AW-1:0] A_HACT  = AW'(2);
  localparam logic [AW-1:0] A_HSB   = AW'(3);
  localparam logic [AW-1:0] A_HSF   = AW'(4);
  localparam logic [AW-1:0] A_VTOT  = AW'(5);
  localparam logic [AW-1:0] A_VACT  = AW'(6);
  localparam logic [AW-1:0] A_VSB   = AW'(7);
  localparam logic [AW-1:0] A_VSF   = AW'(8);
  localparam logic [AW-1:0] A_PFPOS = AW'(9);
  localparam logic [AW-1:0] A_SYNC  = AW'(10);
  localparam logic [AW-1:0] A_DISP  = AW'(11);

  logic [1:0]    ctrl;
  logic [HW-1:0] htot, hact, hsb, hsf, pfpos;
  logic [VW-1:0] vtot, vact, vsb, vsf;
  logic [6:0]    sctl;
  logic          doff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; htot <= '0; hact <= '0; hsb <= '0; hsf <= '0; pfpos <= '0;
      vtot <= '0; vact <= '0; vsb <= '0; vsf <= '0; sctl <= '0; doff <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl  <= wr_data[1:0];
        A_HTOT:  htot  <= wr_data;
        A_HACT:  hact  <= wr_data;
        A_HSB:   hsb   <= wr_data;
        A_HSF:   hsf   <= wr_data;
        A_VTOT:  vtot  <= wr_data[VW-1:0];
        A_VACT:  vact  <= wr_data[VW-1:0];
        A_VSB:   vsb   <= wr_data[VW-1:0];
        A_VSF:   vsf   <= wr_data[VW-1:0];
        A_PFPOS: pfpos <= wr_data;
        A_SYNC:  sctl  <= wr_data[6:0];
        A_DISP:  doff  <= wr_data[1];
        default: ;
      endcase
    end
  end

  wire       ctrl_wr = wr_en && (wr_addr == A_CTRL);
  wire [1:0] ctrl_nx = ctrl_wr ? wr_data[1:0] : ctrl;
  wire       live    = ctrl_nx[0];
  wire       step    = ctrl[0] && live;
  wire       eol     = hcount >= htot;

  wire [HW-1:0] nh = !step ? '0 : (eol ? '0 : hcount + HW'(1));
  wire [VW-1:0] nv = !step ? '0 : (!eol ? vcount : ((vcount >= vtot) ? '0 : vcount + VW'(1)));

  wire de_n   = live && (nh <= hact) && (nv <= vact);
  wire hs_raw = live && (hsb < nh) && (nh <= hsf);
  wire vs_raw = live && (vsb < nv) && (nv <= vsf);
  wire alloff = sctl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcount <= '0; vcount <= '0; de <= 1'b0; pix_en <= 1'b0;
      hsync <= 1'b0; vsync <= 1'b0; csync_rgb <= 1'b0; prefetch <= 1'b0;
    end else begin
      hcount    <= nh;
      vcount    <= nv;
      de        <= de_n;
      pix_en    <= de_n && ctrl_nx[1] && !doff;
      hsync     <= (alloff || sctl[5]) ? 1'b0 : (hs_raw ^ sctl[3]);
      vsync     <= (alloff || sctl[6]) ? 1'b0 : (vs_raw ^ sctl[4]);
      csync_rgb <= sctl[0] && !alloff && (hs_raw || vs_raw);
      prefetch  <= live && (nh == pfpos);
    end
  end

  // R1: stopped generator shows the idle state
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl_wr) |=> (hcount == '0 && vcount == '0 && !de && !prefetch && !csync_rgb));

  // R2: pixel counter steps by one inside the line
  p_hstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl_wr && hcount < htot) |=> (hcount == $past(hcount) + HW'(1)));

  // R2: pixel counter wraps after the line total
  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && hcount == htot) |=> (hcount == '0));

  // R3: line counter holds within a line
  p_vhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl_wr && hcount < htot) |=> $stable(vcount));

  // R6: prefetch is a single-clock pulse on lines longer than one pixel
  p_pf_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prefetch && htot != '0 && !wr_en) |=> !prefetch);

  // R8: all-sync-off silences both syncs
  p_alloff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sctl[1] |=> (!hsync && !vsync && !csync_rgb));

  // R10: colour enable never outside the display region
  p_pix_in_de_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> de);

endmodule

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [12:0] hcount;
  logic [11:0] vcount;
  logic de, pix_en, hsync, vsync, csync_rgb, prefetch;

  int n_tests = 0;
  int n_fail  = 0;
  int g_ht, g_hd, g_hs0, g_hs1, g_vt, g_vd, g_vs0, g_vs1, g_pf, g_sc, g_doff, g_ref;
  int mh, mv;

  always #10 clk = ~clk;

  raster_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hcount(hcount), .vcount(vcount), .de(de), .pix_en(pix_en), .hsync(hsync),
    .vsync(vsync), .csync_rgb(csync_rgb), .prefetch(prefetch)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", tag, act, exp, mh, mv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[12:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int exp_sync(input int raw, input int inv_bit, input int off_bit);
    if (g_sc[1] || g_sc[off_bit]) return 0;
    return raw ^ int'(g_sc[inv_bit]);
  endfunction

  task automatic check_idle(input string why);
    chk({"R1 hcount ", why}, int'(hcount), 0);
    chk({"R1 vcount ", why}, int'(vcount), 0);
    chk({"R1 de ", why}, int'(de), 0);
    chk({"R1 pix_en ", why}, int'(pix_en), 0);
    chk({"R1 prefetch ", why}, int'(prefetch), 0);
    chk({"R1 csync ", why}, int'(csync_rgb), 0);
    chk({"R1 hsync idle level ", why}, int'(hsync), exp_sync(0, 3, 5));
    chk({"R1 vsync idle level ", why}, int'(vsync), exp_sync(0, 4, 6));
  endtask

  task automatic check_live();
    int hr, vr, d;
    hr = (g_hs0 < mh && mh <= g_hs1) ? 1 : 0;
    vr = (g_vs0 < mv && mv <= g_vs1) ? 1 : 0;
    d  = (mh <= g_hd && mv <= g_vd) ? 1 : 0;
    chk("R2 hcount", int'(hcount), mh);
    chk("R3 vcount", int'(vcount), mv);
    chk("R4 de", int'(de), d);
    chk("R5 R7 R8 hsync", int'(hsync), exp_sync(hr, 3, 5));
    chk("R5 R7 R8 vsync", int'(vsync), exp_sync(vr, 4, 6));
    chk("R6 prefetch", int'(prefetch), (mh == g_pf) ? 1 : 0);
    chk("R9 csync", int'(csync_rgb), (g_sc[0] && !g_sc[1]) ? (hr | vr) : 0);
    chk("R10 pix_en", int'(pix_en), (d && g_ref && !g_doff) ? 1 : 0);
  endtask

  task automatic run_cfg(input int ht, input int hd, input int hs0, input int hs1,
                         input int vt, input int vd, input int vs0, input int vs1,
                         input int pf, input int sc, input int dof, input int refr);
    int n;
    g_ht = ht; g_hd = hd; g_hs0 = hs0; g_hs1 = hs1; g_vt = vt; g_vd = vd;
    g_vs0 = vs0; g_vs1 = vs1; g_pf = pf; g_sc = sc; g_doff = dof; g_ref = refr;
    wr(1, ht); wr(2, hd); wr(3, hs0); wr(4, hs1); wr(5, vt); wr(6, vd);
    wr(7, vs0); wr(8, vs1); wr(9, pf); wr(10, sc); wr(11, dof << 1);
    check_idle("after programming");
    wr(0, (refr << 1) | 1);
    mh = 0; mv = 0;
    n = (ht + 1) * (vt + 1) * 2 + 3;
    for (int i = 0; i < n; i++) begin
      check_live();
      if (mh >= g_ht) begin
        mh = 0;
        mv = (mv >= g_vt) ? 0 : mv + 1;
      end else mh++;
      @(negedge clk);
    end
    wr(0, 0);
    mh = 0; mv = 0;
    check_idle("after disable");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    g_sc = 0; mh = 0; mv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("at reset");
    // directed: typical geometry, normal polarity, sync-on-RGB, refresh on
    run_cfg(19, 11, 13, 15, 9, 5, 6, 7, 17, 32'h01, 0, 1);
    // directed: inverted syncs, idle level checked while stopped
    run_cfg(15, 9, 10, 12, 7, 4, 5, 6, 15, 32'h18, 0, 1);
    // directed: one-pixel line, prefetch every cycle, full-frame visible
    run_cfg(0, 0, 0, 0, 5, 5, 1, 3, 0, 32'h00, 0, 1);
    // directed: empty sync windows, display-off, refresh clear
    run_cfg(11, 11, 4, 4, 4, 4, 2, 2, 3, 32'h09, 1, 0);
    // directed: suppression variants
    run_cfg(13, 7, 8, 10, 6, 3, 4, 5, 9, 32'h23, 0, 1);
    run_cfg(13, 7, 8, 10, 6, 3, 4, 5, 9, 32'h41, 0, 1);
    run_cfg(13, 7, 8, 10, 6, 3, 4, 5, 9, 32'h1b, 0, 1);
    // random geometries
    for (int k = 0; k < 10; k++) begin
      int ht, vt;
      ht = 2 + int'($urandom_range(28));
      vt = 2 + int'($urandom_range(12));
      run_cfg(ht, int'($urandom_range(ht)), int'($urandom_range(ht)), int'($urandom_range(ht)),
              vt, int'($urandom_range(vt)), int'($urandom_range(vt)), int'($urandom_range(vt)),
              int'($urandom_range(ht)), int'($urandom_range(127)),
              int'($urandom_range(1)), int'($urandom_range(1)));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule